// File: doc/BRIEF.md
# Stereo Audio Decimation Chain

This block turns two one-bit oversampled streams, one per audio channel and each running at 128 times the audio sample rate, into 20-bit signed PCM words at the audio rate. Each channel passes through an identical filter chain. The first stage is a third-order sinc decimator that reduces the rate by 16. It is followed by three half-band FIR stages in series, and each of these halves the rate again.

Modulator bits are presented together with a clock enable that marks each oversampled slot. Both PCM words update together and are marked by a one-cycle valid strobe, so a serializer or a DC-removal stage can consume them directly. Internal arithmetic runs at a width that holds any transient. The result is rounded once per half-band stage and clipped to 20 bits at the output.

Top module: `dec_chain_top`

## Requirements
- R1: An input bit of 1 counts as +1 and an input bit of 0 counts as -1; a channel fed only zeros settles to -524288.
- R2: `pcm_valid_o` is high for exactly one cycle per output sample, and the n-th pulse after reset is caused by the enable cycle that carries the (128·n)-th accepted bit.
- R3: For a channel fed a repeating 16-bit pattern containing k ones, the settled output equals (2k-16)·32768, clipped to the 20-bit signed range.
- R4: The two channels are filtered independently; the output of one does not depend on the stream of the other.
- R5: Results above 524287 or below -524288 are clipped to those limits; a channel fed only ones settles to 524287.
- R6: While `rst_ni` is low, both PCM outputs are 0 and `pcm_valid_o` is low, and all filter state and decimation phases are cleared.
- R7: The PCM outputs change only in cycles where `pcm_valid_o` is high.
- R8: In cycles where `bit_en_i` is low, the input bits are ignored and no filter state advances, so a stall of any length neither produces a strobe nor disturbs the settled result.
- R9: The first strobe after reset appears four clock cycles after the edge that samples the 128th enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Marks a cycle that carries one oversampled bit per channel |
| bit_l_i | input | 1 | Left modulator bit |
| bit_r_i | input | 1 | Right modulator bit |
| pcm_l_o | output | 20 | Left PCM sample, two's complement |
| pcm_r_o | output | 20 | Right PCM sample, two's complement |
| pcm_valid_o | output | 1 | One-cycle strobe marking a new pair of samples |

## Verification
The bench builds the block with its default parameters: a 4-bit sinc decimation exponent, third order, three half-band stages and 20-bit output. These are the values at which a full-scale input of all ones overflows the output range by exactly one LSB, so the clipping path is reached with ordinary stimulus. Random 16-bit repeating patterns are fed with random enable gaps. Because each pattern's period matches the sinc decimation factor, its settled output is an exact integer that can be predicted without modelling the filter taps. The same stimulus also exercises the strobe spacing counted in accepted bits, a long enable stall, and a reset in the middle of a run.

// File: rtl/dec_pkg.sv
package dec_pkg;
  // half-band kernel: [-1 0 9 16 9 0 -1] / 32
  localparam int HB_TAPS   = 7;
  localparam int HB_MID    = HB_TAPS / 2;
  localparam int HB_OUTER  = -1;
  localparam int HB_INNER  = 9;
  localparam int HB_CENTER = 16;
  localparam int HB_SHIFT  = 5;
  localparam int HB_GROW   = 6;

  typedef enum logic {PH_EVEN = 1'b0, PH_ODD = 1'b1} hb_phase_e;
endpackage

// File: rtl/dec_cic.sv
module dec_cic #(
  parameter int ORDER = 3,
  parameter int LOG2  = 4,
  parameter int W     = ORDER * LOG2 + 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                bit_i,
  output logic signed [W-1:0] data_o,
  output logic                valid_o
);
  localparam logic signed [W-1:0] GAIN = W'(1 << (ORDER * LOG2));

  logic signed [W-1:0] int_q  [ORDER];
  logic signed [W-1:0] comb_q [ORDER];
  logic signed [W-1:0] diff   [ORDER];
  logic signed [W-1:0] x;
  logic [LOG2-1:0]     cnt_q;

  // +1 / -1 in two's complement
  assign x = {{(W-1){~bit_i}}, 1'b1};

  always_comb begin
    diff[0] = int_q[ORDER-1] - comb_q[0];
    for (int k = 1; k < ORDER; k++) diff[k] = diff[k-1] - comb_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < ORDER; k++) begin
        int_q[k]  <= '0;
        comb_q[k] <= '0;
      end
      cnt_q   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (en_i) begin
        int_q[0] <= int_q[0] + x;
        for (int k = 1; k < ORDER; k++) int_q[k] <= int_q[k] + int_q[k-1];
        cnt_q <= cnt_q + 1'b1;
        if (&cnt_q) begin
          comb_q[0] <= int_q[ORDER-1];
          for (int k = 1; k < ORDER; k++) comb_q[k] <= diff[k-1];
          data_o  <= diff[ORDER-1];
          valid_o <= 1'b1;
        end
      end
    end
  end

  p_cic_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (data_o <= GAIN && data_o >= -GAIN));
  p_cic_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(en_i));
  p_cic_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(int_q[ORDER-1]) && $stable(cnt_q));
endmodule

// File: rtl/dec_hb2.sv
module dec_hb2
  import dec_pkg::*;
#(
  parameter int W = 22
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic signed [W-1:0] data_i,
  output logic                valid_o,
  output logic signed [W-1:0] data_o
);
  localparam int AW = W + HB_GROW;
  localparam logic signed [AW-1:0] C_OUT = AW'(HB_OUTER);
  localparam logic signed [AW-1:0] C_IN  = AW'(HB_INNER);
  localparam logic signed [AW-1:0] C_CEN = AW'(HB_CENTER);
  localparam logic signed [AW-1:0] RND   = AW'(1 << (HB_SHIFT - 1));

  logic signed [W-1:0]  dly_q [HB_TAPS-1];
  logic signed [AW-1:0] win   [HB_TAPS];
  logic signed [AW-1:0] acc;
  hb_phase_e            phase_q;

  always_comb begin
    win[0] = AW'(data_i);
    for (int k = 1; k < HB_TAPS; k++) win[k] = AW'(dly_q[k-1]);
    acc = C_OUT * (win[0] + win[2*HB_MID])
        + C_IN  * (win[HB_MID-1] + win[HB_MID+1])
        + C_CEN * win[HB_MID] + RND;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < HB_TAPS-1; k++) dly_q[k] <= '0;
      phase_q <= PH_EVEN;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      if (valid_i) begin
        dly_q[0] <= data_i;
        for (int k = 1; k < HB_TAPS-1; k++) dly_q[k] <= dly_q[k-1];
        phase_q <= (phase_q == PH_EVEN) ? PH_ODD : PH_EVEN;
        if (phase_q == PH_ODD) begin
          data_o  <= W'(acc >>> HB_SHIFT);
          valid_o <= 1'b1;
        end
      end
    end
  end

  p_hb_half_rate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/dec_chain_top.sv
module dec_chain_top #(
  parameter int PCM_W     = 20,
  parameter int CIC_ORDER = 3,
  parameter int CIC_LOG2  = 4,
  parameter int HB_STAGES = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             bit_l_i,
  input  logic             bit_r_i,
  output logic [PCM_W-1:0] pcm_l_o,
  output logic [PCM_W-1:0] pcm_r_o,
  output logic             pcm_valid_o
);
  localparam int CH     = 2;
  localparam int CIC_W  = CIC_ORDER * CIC_LOG2 + 2;
  localparam int MID_W  = PCM_W + 2;
  localparam int PRE_SH = PCM_W - 1 - CIC_ORDER * CIC_LOG2;
  localparam logic signed [MID_W-1:0] PMAX = MID_W'((1 << (PCM_W - 1)) - 1);
  localparam logic signed [MID_W-1:0] PMIN = -PMAX - MID_W'(1);

  logic [CH-1:0]             in_bits;
  logic signed [CIC_W-1:0]   cic_d [CH];
  logic                      cic_v [CH];
  logic signed [MID_W-1:0]   stg_d [CH][HB_STAGES+1];
  logic                      stg_v [CH][HB_STAGES+1];
  logic signed [PCM_W-1:0]   sat_d [CH];

  assign in_bits = {bit_r_i, bit_l_i};

  for (genvar c = 0; c < CH; c++) begin : g_ch
    dec_cic #(.ORDER(CIC_ORDER), .LOG2(CIC_LOG2), .W(CIC_W)) u_cic (
      .clk_i, .rst_ni,
      .en_i   (bit_en_i),
      .bit_i  (in_bits[c]),
      .data_o (cic_d[c]),
      .valid_o(cic_v[c])
    );

    assign stg_d[c][0] = MID_W'(cic_d[c]) <<< PRE_SH;
    assign stg_v[c][0] = cic_v[c];

    for (genvar s = 0; s < HB_STAGES; s++) begin : g_hb
      dec_hb2 #(.W(MID_W)) u_hb (
        .clk_i, .rst_ni,
        .valid_i(stg_v[c][s]),
        .data_i (stg_d[c][s]),
        .valid_o(stg_v[c][s+1]),
        .data_o (stg_d[c][s+1])
      );
    end

    always_comb begin
      if (stg_d[c][HB_STAGES] > PMAX)      sat_d[c] = PCM_W'(PMAX);
      else if (stg_d[c][HB_STAGES] < PMIN) sat_d[c] = PCM_W'(PMIN);
      else                                 sat_d[c] = PCM_W'(stg_d[c][HB_STAGES]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcm_l_o     <= '0;
      pcm_r_o     <= '0;
      pcm_valid_o <= 1'b0;
    end else begin
      pcm_valid_o <= stg_v[0][HB_STAGES] & stg_v[1][HB_STAGES];
      if (stg_v[0][HB_STAGES] & stg_v[1][HB_STAGES]) begin
        pcm_l_o <= sat_d[0];
        pcm_r_o <= sat_d[1];
      end
    end
  end

  p_strobe_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcm_valid_o |=> !pcm_valid_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pcm_valid_o |-> $stable(pcm_l_o) && $stable(pcm_r_o));
  p_lockstep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stg_v[0][HB_STAGES] == stg_v[1][HB_STAGES]);
endmodule

// File: tb/tb_dec_chain_top.sv
module tb_dec_chain_top;
  localparam int CLK_PERIOD = 10;
  localparam int OSR        = 128;
  localparam int LAT        = 5;
  localparam int SETTLE     = 7;
  localparam int NOUT       = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_en_i = 1'b0;
  logic        bit_l_i = 1'b0;
  logic        bit_r_i = 1'b0;
  logic [19:0] pcm_l_o, pcm_r_o;
  logic        pcm_valid_o;

  dec_chain_top dut (
    .clk_i, .rst_ni, .bit_en_i, .bit_l_i, .bit_r_i,
    .pcm_l_o, .pcm_r_o, .pcm_valid_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  int en_cnt = 0, n_valid = 0, cyc = 0, bidx = 0;
  int en_hist [8];
  int exp_l = 0, exp_r = 0, chk_from = 1 << 30, hold_err = 0;
  logic [15:0] pat_l = '0, pat_r = '0;
  logic [19:0] prev_l = '0, prev_r = '0;
  string tag_l = "R3", tag_r = "R3";
  bit done = 1'b0;

  function automatic int expect_pcm(logic [15:0] p);
    int v;
    v = (2 * $countones(p) - 16) * 32768;
    if (v > 524287) v = 524287;
    if (v < -524288) v = -524288;
    return v;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step(bit en);
    int al, ar, h0, h1;
    @(negedge clk_i);
    cyc++;
    al = int'($signed(pcm_l_o));
    ar = int'($signed(pcm_r_o));
    if (pcm_valid_o) begin
      n_valid++;
      h0 = en_hist[(cyc - LAT) & 7];
      h1 = en_hist[(cyc - LAT - 1) & 7];
      check(h0 == OSR * n_valid && h1 == OSR * n_valid - 1,
            (n_valid == 1) ? "R9 first strobe" : "R2 strobe spacing", h0, OSR * n_valid);
      if (n_valid >= chk_from) begin
        check(al == exp_l, tag_l, al, exp_l);
        check(ar == exp_r, tag_r, ar, exp_r);
      end
    end else if (pcm_l_o !== prev_l || pcm_r_o !== prev_r) begin
      hold_err++;
    end
    prev_l = pcm_l_o;
    prev_r = pcm_r_o;
    bit_en_i = en;
    if (en) begin
      bit_l_i = pat_l[bidx];
      bit_r_i = pat_r[bidx];
      bidx = (bidx + 1) % 16;
      en_cnt++;
    end else begin
      bit_l_i = 1'($urandom % 2);
      bit_r_i = 1'($urandom % 2);
    end
    en_hist[cyc & 7] = en_cnt;
  endtask

  task automatic run_pattern(logic [15:0] pl, logic [15:0] pr, string tl, string tr);
    pat_l = pl;
    pat_r = pr;
    exp_l = expect_pcm(pl);
    exp_r = expect_pcm(pr);
    tag_l = tl;
    tag_r = tr;
    chk_from = n_valid + SETTLE;
    while (n_valid < chk_from + NOUT - 1) step(($urandom % 4) != 0);
    check(hold_err == 0, "R7 hold between strobes", hold_err, 0);
    hold_err = 0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    bit_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(pcm_l_o == '0 && pcm_r_o == '0, "R6 reset outputs",
          int'($signed(pcm_l_o)), 0);
    check(pcm_valid_o == 1'b0, "R6 reset strobe", int'(pcm_valid_o), 0);
    rst_ni = 1'b1;
    en_cnt = 0; n_valid = 0; cyc = 0; bidx = 0;
    for (int i = 0; i < 8; i++) en_hist[i] = 0;
    prev_l = '0; prev_r = '0;
    chk_from = 1 << 30;
  endtask

  initial begin
    int unsigned seed_v;
    int nv;
    logic [19:0] sl, sr;
    seed_v = $urandom(24681);
    for (int i = 0; i < 8; i++) en_hist[i] = 0;
    do_reset();

    run_pattern(16'hFFFF, 16'h0000, "R5 left clip high", "R1 right all zeros");
    run_pattern(16'h0000, 16'hFFFF, "R1 left all zeros", "R4 right clip high");
    run_pattern(16'h00FF, 16'h5555, "R3 left half density", "R3 right alternating");
    run_pattern(16'h0FFF, 16'h0007, "R3 left k=12", "R4 right k=3");

    // stall: bits toggle while enable is low
    nv = n_valid; sl = pcm_l_o; sr = pcm_r_o;
    repeat (300) step(1'b0);
    check(n_valid == nv, "R8 no strobe during stall", n_valid, nv);
    check(pcm_l_o == sl && pcm_r_o == sr, "R8 outputs frozen in stall",
          int'($signed(pcm_l_o)), int'($signed(sl)));
    chk_from = n_valid + 1;
    tag_l = "R8 left after stall";
    tag_r = "R8 right after stall";
    while (n_valid < chk_from + 2) step(($urandom % 4) != 0);

    for (int t = 0; t < 8; t++) begin
      run_pattern(16'($urandom), 16'($urandom), "R3 left random", "R4 right random");
    end

    do_reset();
    run_pattern(16'h3C3C, 16'hFFF0, "R6 left after reset", "R6 right after reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule